// File: doc/BRIEF.md
# Overlapping General Register Stack

A stack of 128 words, 36 bits each, that a processor sees two ways at once. Through the designator path it names a register by kind (index, accumulator or special) plus a 4-bit number. Through the address path it names a word directly by a 7-bit address, so the stack also forms the lowest 128 words of the memory space. A mode input picks whether the designator path works on the user copy of the register set or on the executive copy. The executive copy sits 64 words above the user copy.

Index and accumulator names are laid out so that the last four index registers and the first four accumulators are the same physical words. A program can therefore treat those words as either kind. The accumulator path also supports double-word transfers on a register and the word that follows it. A double-word access on the last accumulator reaches a word that has no register name.

Writes take effect on the clock edge. Reads are combinational and show data being written in the same cycle. When both paths write the same word in one cycle, the designator path wins.

Top module: `gr_stack`

## Requirements
- R1: After the asynchronous reset rst_ni, every word of the stack reads as zero on the address path.
- R2: The address path writes any of the 128 words (addresses 0 to 127) on the clock edge when ab_we_i is high. It returns the word at ab_addr_i on ab_rdata_o combinationally.
- R3: Designator kinds are encoded on dz_kind_i as 0 = index, 1 = accumulator, 2 = special, 3 = none. In the user set, index n maps to address n, accumulator n to address 12+n, and special n to address 32+n.
- R4: Index 12..15 and accumulator 0..3 are the same words. A write through one name is read back through the other.
- R5: Index 0, special 0 and kind 3 read as zero on dz_rdata_lo_o, whatever the addressed word holds. A designator write to them changes no word.
- R6: With dz_dbl_i high and kind accumulator, the access covers the named word (low, dz_wdata_lo_i / dz_rdata_lo_o) and the next address (high, dz_wdata_hi_i / dz_rdata_hi_o). Accumulator 15 pairs with address 28. For a single access, or any other kind, dz_rdata_hi_o is zero and no high word is written.
- R7: With exec_i high, every designator address is offset by 64. The executive set is updated without disturbing the user set.
- R8: A read of a word in the same cycle as a write to it, from either path, returns the new data.
- R9: If both paths write the same word in one cycle, the word takes the designator data. The address port reads that data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Selects the executive register set for the designator path |
| dz_kind_i | input | 2 | Designator kind (0 index, 1 accumulator, 2 special, 3 none) |
| dz_num_i | input | 4 | Register number within the kind |
| dz_dbl_i | input | 1 | Double-word access (accumulators only) |
| dz_we_i | input | 1 | Designator write enable |
| dz_wdata_lo_i | input | 36 | Write data for the named word |
| dz_wdata_hi_i | input | 36 | Write data for the following word in a double access |
| dz_rdata_lo_o | output | 36 | Read data of the named word |
| dz_rdata_hi_o | output | 36 | Read data of the following word in a double access |
| ab_addr_i | input | 7 | Word address for the address path |
| ab_we_i | input | 1 | Address path write enable |
| ab_wdata_i | input | 36 | Address path write data |
| ab_rdata_o | output | 36 | Address path read data |

## Verification
A designator write and an address path access can land on the same word in the same cycle. The bench provokes this in two ways. First, it writes index 3 by designator while the address port reads address 3, and expects the new value on ab_rdata_o in that cycle. Second, it drives writes from both paths to the word of accumulator 5 together, and expects the designator data both in that cycle and on a later read. Aliasing is judged the same way: a value written under an index name must appear under the overlapping accumulator name and at the computed address.

// File: rtl/gr_pkg.sv
package gr_pkg;
  typedef enum logic [1:0] {
    DZ_X    = 2'd0,
    DZ_A    = 2'd1,
    DZ_R    = 2'd2,
    DZ_NONE = 2'd3
  } dz_kind_e;
endpackage

// File: rtl/gr_decode.sv
module gr_decode
  import gr_pkg::*;
#(
  parameter int AW     = 7,
  parameter int NUM_W  = 4,
  parameter int A_BASE = 12,
  parameter int R_BASE = 32
) (
  input  logic             exec_i,
  input  dz_kind_e         kind_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             dbl_i,
  output logic [AW-1:0]    lo_addr_o,
  output logic             lo_vld_o,
  output logic [AW-1:0]    hi_addr_o,
  output logic             hi_vld_o
);
  localparam logic [AW-1:0] SET_OFS = AW'(1) << (AW - 1);

  logic [AW-1:0] base;
  always_comb begin
    unique case (kind_i)
      DZ_A:    base = AW'(A_BASE);
      DZ_R:    base = AW'(R_BASE);
      default: base = '0;
    endcase
  end

  assign lo_addr_o = base + AW'(num_i) + (exec_i ? SET_OFS : '0);
  // number zero of index/special kinds is the hardwired zero register
  assign lo_vld_o  = (kind_i == DZ_A) ||
                     (((kind_i == DZ_X) || (kind_i == DZ_R)) && (num_i != '0));
  assign hi_addr_o = lo_addr_o + AW'(1);
  assign hi_vld_o  = lo_vld_o && (kind_i == DZ_A) && dbl_i;
endmodule

// File: rtl/gr_store.sv
module gr_store #(
  parameter int DW = 36,
  parameter int AW = 7,
  parameter int NP = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0]          we_i,
  input  logic [NP-1:0][AW-1:0]  waddr_i,
  input  logic [NP-1:0][DW-1:0]  wdata_i,
  input  logic [NP-1:0][AW-1:0]  raddr_i,
  output logic [NP-1:0][DW-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // port 0 is applied last, so it has the highest priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        for (int p = NP - 1; p >= 0; p--) begin
          if (we_i[p] && (waddr_i[p] == AW'(w))) mem[w] <= wdata_i[p];
        end
      end
    end
  end

  for (genvar r = 0; r < NP; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end

  assert_hi_prio_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[0] |=> mem[$past(waddr_i[0])] == $past(wdata_i[0]));
endmodule

// File: rtl/gr_bypass.sv
module gr_bypass #(
  parameter int DW = 36,
  parameter int AW = 7,
  parameter int NP = 3
) (
  input  logic [AW-1:0]          raddr_i,
  input  logic [DW-1:0]          mem_data_i,
  input  logic [NP-1:0]          we_i,
  input  logic [NP-1:0][AW-1:0]  waddr_i,
  input  logic [NP-1:0][DW-1:0]  wdata_i,
  output logic [DW-1:0]          rdata_o
);
  // same priority order as the store: port 0 last
  always_comb begin
    rdata_o = mem_data_i;
    for (int p = NP - 1; p >= 0; p--) begin
      if (we_i[p] && (waddr_i[p] == raddr_i)) rdata_o = wdata_i[p];
    end
  end
endmodule

// File: rtl/gr_stack.sv
module gr_stack
  import gr_pkg::*;
#(
  parameter int DW     = 36,
  parameter int AW     = 7,
  parameter int NUM_W  = 4,
  parameter int A_BASE = 12,
  parameter int R_BASE = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic [1:0]       dz_kind_i,
  input  logic [NUM_W-1:0] dz_num_i,
  input  logic             dz_dbl_i,
  input  logic             dz_we_i,
  input  logic [DW-1:0]    dz_wdata_lo_i,
  input  logic [DW-1:0]    dz_wdata_hi_i,
  output logic [DW-1:0]    dz_rdata_lo_o,
  output logic [DW-1:0]    dz_rdata_hi_o,
  input  logic [AW-1:0]    ab_addr_i,
  input  logic             ab_we_i,
  input  logic [DW-1:0]    ab_wdata_i,
  output logic [DW-1:0]    ab_rdata_o
);
  localparam int NP = 3;  // 0: designator low, 1: designator high, 2: address path

  logic [AW-1:0] lo_addr, hi_addr;
  logic          lo_vld, hi_vld;

  gr_decode #(.AW(AW), .NUM_W(NUM_W), .A_BASE(A_BASE), .R_BASE(R_BASE)) u_decode (
    .exec_i    (exec_i),
    .kind_i    (dz_kind_e'(dz_kind_i)),
    .num_i     (dz_num_i),
    .dbl_i     (dz_dbl_i),
    .lo_addr_o (lo_addr),
    .lo_vld_o  (lo_vld),
    .hi_addr_o (hi_addr),
    .hi_vld_o  (hi_vld)
  );

  logic [NP-1:0]         we;
  logic [NP-1:0][AW-1:0] addr;
  logic [NP-1:0][DW-1:0] wdata;
  logic [NP-1:0][DW-1:0] mem_rd;
  logic [NP-1:0][DW-1:0] byp_rd;

  assign we    = {ab_we_i, dz_we_i && hi_vld, dz_we_i && lo_vld};
  assign addr  = {ab_addr_i, hi_addr, lo_addr};
  assign wdata = {ab_wdata_i, dz_wdata_hi_i, dz_wdata_lo_i};

  gr_store #(.DW(DW), .AW(AW), .NP(NP)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (addr),
    .wdata_i (wdata),
    .raddr_i (addr),
    .rdata_o (mem_rd)
  );

  for (genvar r = 0; r < NP; r++) begin : g_byp
    gr_bypass #(.DW(DW), .AW(AW), .NP(NP)) u_byp (
      .raddr_i    (addr[r]),
      .mem_data_i (mem_rd[r]),
      .we_i       (we),
      .waddr_i    (addr),
      .wdata_i    (wdata),
      .rdata_o    (byp_rd[r])
    );
  end

  assign dz_rdata_lo_o = lo_vld ? byp_rd[0] : '0;
  assign dz_rdata_hi_o = hi_vld ? byp_rd[1] : '0;
  assign ab_rdata_o    = byp_rd[2];

  assert_zero_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dz_kind_i != 2'd1) && (dz_num_i == '0)) |-> (dz_rdata_lo_o == '0));

  assert_single_hi_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dz_dbl_i && (dz_kind_i == 2'd1)) |-> (dz_rdata_hi_o == '0));

  assert_addr_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_we_i && !dz_we_i) |=>
      ((ab_addr_i != $past(ab_addr_i)) || dz_we_i || ab_we_i ||
       (ab_rdata_o == $past(ab_wdata_i))));

  assert_collide_same_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_we_i && we[0] && (addr[0] == ab_addr_i)) |-> (ab_rdata_o == dz_wdata_lo_i));
endmodule

// File: tb/gr_stack_tb.sv
module gr_stack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_m = 1'b0;
  logic [1:0]  kind = 2'd3;
  logic [3:0]  num = '0;
  logic        dbl = 1'b0;
  logic        dz_we = 1'b0;
  logic [35:0] wlo = '0, whi = '0;
  logic [35:0] rlo, rhi;
  logic [6:0]  aaddr = '0;
  logic        awe = 1'b0;
  logic [35:0] awdata = '0;
  logic [35:0] ardata;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  gr_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec_m),
    .dz_kind_i(kind), .dz_num_i(num), .dz_dbl_i(dbl), .dz_we_i(dz_we),
    .dz_wdata_lo_i(wlo), .dz_wdata_hi_i(whi),
    .dz_rdata_lo_o(rlo), .dz_rdata_hi_o(rhi),
    .ab_addr_i(aaddr), .ab_we_i(awe), .ab_wdata_i(awdata), .ab_rdata_o(ardata)
  );

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    dz_we = 1'b0; awe = 1'b0; dbl = 1'b0; kind = 2'd3; exec_m = 1'b0;
  endtask

  // one-cycle designator write
  task automatic dz_wr(input bit ex, input logic [1:0] k, input logic [3:0] n,
                       input bit d, input logic [35:0] lo, input logic [35:0] hi);
    @(negedge clk);
    idle();
    exec_m = ex; kind = k; num = n; dbl = d; wlo = lo; whi = hi; dz_we = 1'b1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic ab_wr(input logic [6:0] a, input logic [35:0] v);
    @(negedge clk);
    idle();
    aaddr = a; awdata = v; awe = 1'b1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic ab_chk(input string tag, input logic [6:0] a, input logic [35:0] exp);
    @(negedge clk);
    idle();
    aaddr = a;
    #1 check(tag, ardata, exp);
  endtask

  task automatic dz_chk(input string tag, input bit ex, input logic [1:0] k,
                        input logic [3:0] n, input bit d,
                        input logic [35:0] elo, input logic [35:0] ehi);
    @(negedge clk);
    idle();
    exec_m = ex; kind = k; num = n; dbl = d;
    #1;
    check({tag, " lo"}, rlo, elo);
    check({tag, " hi"}, rhi, ehi);
  endtask

  task automatic t_reset();  // R1
    ab_chk("R1 reset addr0", 7'd0, '0);
    ab_chk("R1 reset addr12", 7'd12, '0);
    ab_chk("R1 reset addr127", 7'd127, '0);
  endtask

  task automatic t_addr();  // R2
    ab_wr(7'd0, 36'h123456789);
    ab_wr(7'd64, 36'hFFFFFFFFF);
    ab_wr(7'd127, 36'hA5A5A5A5A);
    ab_chk("R2 addr0", 7'd0, 36'h123456789);
    ab_chk("R2 addr64", 7'd64, 36'hFFFFFFFFF);
    ab_chk("R2 addr127", 7'd127, 36'hA5A5A5A5A);
  endtask

  task automatic t_map();  // R3
    dz_wr(1'b0, 2'd0, 4'd5, 1'b0, 36'h000000005, '0);
    dz_wr(1'b0, 2'd1, 4'd7, 1'b0, 36'h0000000A7, '0);
    dz_wr(1'b0, 2'd2, 4'd9, 1'b0, 36'h0000000C9, '0);
    ab_chk("R3 X5 at 5", 7'd5, 36'h000000005);
    ab_chk("R3 A7 at 19", 7'd19, 36'h0000000A7);
    ab_chk("R3 R9 at 41", 7'd41, 36'h0000000C9);
    ab_wr(7'd47, 36'h0BEEF0015);
    dz_chk("R3 R15 from 47", 1'b0, 2'd2, 4'd15, 1'b0, 36'h0BEEF0015, '0);
  endtask

  task automatic t_alias();  // R4
    dz_wr(1'b0, 2'd0, 4'd13, 1'b0, 36'h13131313D, '0);
    dz_chk("R4 A1 sees X13", 1'b0, 2'd1, 4'd1, 1'b0, 36'h13131313D, '0);
    dz_wr(1'b0, 2'd1, 4'd3, 1'b0, 36'h0A3A3A3A3, '0);
    dz_chk("R4 X15 sees A3", 1'b0, 2'd0, 4'd15, 1'b0, 36'h0A3A3A3A3, '0);
    ab_chk("R4 A3 at 15", 7'd15, 36'h0A3A3A3A3);
  endtask

  task automatic t_zero();  // R5
    // address 0 holds 123456789 from t_addr
    dz_chk("R5 X0 reads zero", 1'b0, 2'd0, 4'd0, 1'b0, '0, '0);
    dz_wr(1'b0, 2'd0, 4'd0, 1'b0, 36'h777777777, '0);
    ab_chk("R5 X0 write ignored", 7'd0, 36'h123456789);
    ab_wr(7'd32, 36'h320320320);
    dz_chk("R5 R0 reads zero", 1'b0, 2'd2, 4'd0, 1'b0, '0, '0);
    dz_wr(1'b0, 2'd2, 4'd0, 1'b0, 36'h555555555, '0);
    ab_chk("R5 R0 write ignored", 7'd32, 36'h320320320);
    ab_wr(7'd4, 36'h044444444);
    dz_chk("R5 kind3 reads zero", 1'b0, 2'd3, 4'd4, 1'b0, '0, '0);
    dz_wr(1'b0, 2'd3, 4'd4, 1'b0, 36'h999999999, '0);
    ab_chk("R5 kind3 write ignored", 7'd4, 36'h044444444);
  endtask

  task automatic t_dbl();  // R6
    dz_wr(1'b0, 2'd1, 4'd15, 1'b1, 36'h0000A15A5, 36'h0000A15B6);
    ab_chk("R6 A15 low at 27", 7'd27, 36'h0000A15A5);
    ab_chk("R6 A15 pair at 28", 7'd28, 36'h0000A15B6);
    dz_chk("R6 dbl read A15", 1'b0, 2'd1, 4'd15, 1'b1, 36'h0000A15A5, 36'h0000A15B6);
    dz_chk("R6 single read A15", 1'b0, 2'd1, 4'd15, 1'b0, 36'h0000A15A5, '0);
    ab_wr(7'd9, 36'h000000009);
    dz_wr(1'b0, 2'd0, 4'd8, 1'b1, 36'h000000008, 36'hBADBADBAD);
    ab_chk("R6 X dbl no high write", 7'd9, 36'h000000009);
    dz_chk("R6 X dbl high zero", 1'b0, 2'd0, 4'd8, 1'b1, 36'h000000008, '0);
  endtask

  task automatic t_exec();  // R7
    dz_wr(1'b0, 2'd1, 4'd2, 1'b0, 36'h00000A2A2, '0);
    dz_wr(1'b1, 2'd1, 4'd2, 1'b0, 36'h0000E2E2E, '0);
    ab_chk("R7 exec A2 at 78", 7'd78, 36'h0000E2E2E);
    ab_chk("R7 user A2 kept at 14", 7'd14, 36'h00000A2A2);
    dz_chk("R7 exec read", 1'b1, 2'd1, 4'd2, 1'b0, 36'h0000E2E2E, '0);
    dz_chk("R7 user read", 1'b0, 2'd1, 4'd2, 1'b0, 36'h00000A2A2, '0);
  endtask

  task automatic t_bypass();  // R8
    @(negedge clk);
    idle();
    aaddr = 7'd50; awdata = 36'h050505050; awe = 1'b1;
    #1 check("R8 addr write-read same cycle", ardata, 36'h050505050);
    @(posedge clk); #1;
    idle();
    @(negedge clk);
    idle();
    kind = 2'd0; num = 4'd3; wlo = 36'h0000033CC; dz_we = 1'b1; aaddr = 7'd3;
    #1;
    check("R8 addr read sees dz write", ardata, 36'h0000033CC);
    check("R8 dz read sees dz write", rlo, 36'h0000033CC);
    @(posedge clk); #1;
    idle();
    ab_chk("R8 value kept", 7'd3, 36'h0000033CC);
  endtask

  task automatic t_prio();  // R9
    @(negedge clk);
    idle();
    kind = 2'd1; num = 4'd5; wlo = 36'h0D0D0D0D0; dz_we = 1'b1;
    aaddr = 7'd17; awdata = 36'h0AAAAAAAA; awe = 1'b1;
    #1 check("R9 same cycle read", ardata, 36'h0D0D0D0D0);
    @(posedge clk); #1;
    idle();
    ab_chk("R9 designator wins", 7'd17, 36'h0D0D0D0D0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_addr();
    t_map();
    t_alias();
    t_zero();
    t_dbl();
    t_exec();
    t_bypass();
    t_prio();
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule